// File: doc/BRIEF.md
# Debug Data-Register Path Selector

This block sits between a standard JTAG TAP controller and an on-chip debug unit and decides what the data-register (DR) path looks like on each scan. Two instruction codes matter. The halt instruction latches a request for the core to stop and leaves a 1-bit bypass stage in the DR path. The debug-access instruction hands the DR path to the debug unit.

Once debug access is selected, the DR length depends on the last command. Every access starts with an 8-bit command scan. That scan shifts a status byte out and a command byte in. If the command asks for a 16-bit transfer, the next DR scan is 16 bits long. A read transfer unloads a register value through TDO. A write transfer delivers a data word with a one-cycle strobe. After either transfer the path returns to 8 bits for the next command.

The halt request persists across later instruction loads and across a TAP reset. It drops only when the core reports the halt as granted.

Top module: `jdbg_dr_select`

## Requirements
- R1: After the synchronous reset `rst`, `halt_req_o`, `cmd_o`, `data_o`, `data_we_o` and `tdo_o` are all zero, and the DR path is the 1-bit bypass stage.
- R2: An Update-IR with instruction code 4'h7 sets `halt_req_o`. It stays set through later Update-IR strobes with other codes and through a TAP reset. It clears on the clock after `halt_granted_i` is high. A grant present in the same cycle as the request wins, so the request does not set.
- R3: While the selected instruction is not 4'h6, the DR path is one bit long. Capture-DR loads 0, so TDO shows 0 and then each TDI bit one shift later. Update-DR leaves `cmd_o`, `data_o` and `data_we_o` unchanged.
- R4: An Update-IR with code 4'h6 selects the 8-bit path. In that path, Capture-DR loads `status_i`, shifting is LSB first, and TDO changes on the falling clock edge. Update-DR copies the 8 shifted-in bits to `cmd_o`.
- R5: The command byte is decoded as follows: bit 7 is read (1) or write (0), bit 6 requests a 16-bit transfer, and bits 5:0 select a register. A command with bit 6 set makes the next DR scan 16 bits long. A command with bit 6 clear keeps the path at 8 bits.
- R6: In the 16-bit path with a write command, Update-DR copies the 16 shifted-in bits to `data_o`, pulses `data_we_o` high for exactly one clock, and returns to the 8-bit path.
- R7: In the 16-bit path with a read command, Capture-DR loads `rd_data_i` and shifts it out LSB first. Update-DR then returns to the 8-bit path, with no write strobe and no change to `data_o`.
- R8: A TAP reset strobe clears `cmd_o` and selects the bypass path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_reset_i | input | 1 | TAP is in Test-Logic-Reset |
| capture_dr_i | input | 1 | TAP Capture-DR state |
| shift_dr_i | input | 1 | TAP Shift-DR state |
| update_dr_i | input | 1 | TAP Update-DR state |
| update_ir_i | input | 1 | TAP Update-IR state |
| tdi_i | input | 1 | Serial test data in |
| ir_code_i | input | IR_W | Instruction held in the IR |
| halt_granted_i | input | 1 | Core reports the halt as granted |
| status_i | input | CMD_W | Status byte captured on a command scan |
| rd_data_i | input | DATA_W | Selected register value for a read |
| tdo_o | output | 1 | Serial test data out, falling-edge timed |
| cmd_o | output | CMD_W | Current command byte |
| data_o | output | DATA_W | Last written data word |
| data_we_o | output | 1 | One-cycle write strobe for data_o |
| halt_req_o | output | 1 | Latched halt request |

## Verification
The 16-bit read and write states are the hardest to reach from the ports. They exist only after a complete 8-bit scan has loaded a wide command, so no single stimulus gets there. The bench therefore chains complete scans: a command scan, then a 16-bit scan, then another command scan. It repeats this chain for every one of the 64 register selects, for reads and for writes. It also follows each narrow command with a second 8-bit scan, which shows that the length did not switch. A separate sequence shows that the halt request survives instruction changes and a TAP reset, and that a grant arriving with the request wins.

// File: rtl/jdbg_pkg.sv
package jdbg_pkg;

    // Which shifter is connected between TDI and TDO
    typedef enum logic [1:0] {
        SEL_BYPASS = 2'd0,
        SEL_CMD    = 2'd1,
        SEL_DATA   = 2'd2
    } path_sel_e;

    // Command byte field positions
    localparam int CMD_RD_BIT   = 7;
    localparam int CMD_WIDE_BIT = 6;

    function automatic logic cmd_is_read(input logic [7:0] c);
        return c[CMD_RD_BIT];
    endfunction

    function automatic logic cmd_is_wide(input logic [7:0] c);
        return c[CMD_WIDE_BIT];
    endfunction

endpackage

// File: rtl/jdbg_halt_latch.sv
module jdbg_halt_latch #(
    parameter int IR_W = 4,
    parameter logic [IR_W-1:0] IR_HALT = 4'h7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            update_ir,
    input  logic [IR_W-1:0] ir_code,
    input  logic            granted,
    output logic            halt_req
);
    logic set_req;
    assign set_req = update_ir && (ir_code == IR_HALT);

    always_ff @(posedge clk) begin
        if (rst) halt_req <= 1'b0;
        else     halt_req <= (halt_req | set_req) & ~granted;
    end

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !granted) |=> halt_req);
    p_halt_clear_r2: assert property (@(posedge clk) disable iff (rst)
        granted |=> !halt_req);
endmodule

// File: rtl/jdbg_shifter.sv
module jdbg_shifter
    import jdbg_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  path_sel_e         sel,
    input  logic              capture,
    input  logic              shift,
    input  logic              load_rd,
    input  logic              tdi,
    input  logic [CMD_W-1:0]  status,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sr,
    output logic              tdo
);
    localparam int PAD_W = DATA_W - CMD_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (capture) begin
            case (sel)
                SEL_CMD:  sr <= {{PAD_W{1'b0}}, status};
                SEL_DATA: if (load_rd) sr <= rd_data;
                default:  sr <= '0;
            endcase
        end else if (shift) begin
            case (sel)
                SEL_CMD:  sr[CMD_W-1:0] <= {tdi, sr[CMD_W-1:1]};
                SEL_DATA: sr <= {tdi, sr[DATA_W-1:1]};
                default:  sr[0] <= tdi;
            endcase
        end
    end

    // TDO is retimed to the falling edge
    always_ff @(negedge clk) begin
        if (rst) tdo <= 1'b0;
        else     tdo <= sr[0];
    end

    p_bypass_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (capture && sel == SEL_BYPASS) |=> (sr[0] == 1'b0));
endmodule

// File: rtl/jdbg_path_fsm.sv
module jdbg_path_fsm
    import jdbg_pkg::*;
#(
    parameter int IR_W   = 4,
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16,
    parameter logic [IR_W-1:0] IR_ACCESS = 4'h6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tap_reset,
    input  logic              update_ir,
    input  logic              update_dr,
    input  logic [IR_W-1:0]   ir_code,
    input  logic [DATA_W-1:0] sr,
    output path_sel_e         sel,
    output logic [CMD_W-1:0]  cmd,
    output logic [DATA_W-1:0] data,
    output logic              data_we
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel     <= SEL_BYPASS;
            cmd     <= '0;
            data    <= '0;
            data_we <= 1'b0;
        end else begin
            data_we <= 1'b0;
            if (tap_reset) begin
                sel <= SEL_BYPASS;
                cmd <= '0;
            end else if (update_ir) begin
                sel <= (ir_code == IR_ACCESS) ? SEL_CMD : SEL_BYPASS;
            end else if (update_dr) begin
                case (sel)
                    SEL_CMD: begin
                        cmd <= sr[CMD_W-1:0];
                        sel <= cmd_is_wide(sr[7:0]) ? SEL_DATA : SEL_CMD;
                    end
                    SEL_DATA: begin
                        if (!cmd_is_read(cmd[7:0])) begin
                            data    <= sr;
                            data_we <= 1'b1;
                        end
                        sel <= SEL_CMD;
                    end
                    default: ;
                endcase
            end
        end
    end

    p_bypass_cmd_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_BYPASS && !tap_reset) |=> $stable(cmd) && !data_we);
    p_wide_next_r5: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CMD && update_dr && !tap_reset && !update_ir)
        |=> ((sel == SEL_DATA) == cmd[CMD_WIDE_BIT]));
    p_we_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        data_we |=> !data_we);
    p_data_return_r6: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_DATA && update_dr && !tap_reset && !update_ir) |=> sel == SEL_CMD);
    p_we_write_only_r7: assert property (@(posedge clk) disable iff (rst)
        data_we |-> !cmd[CMD_RD_BIT]);
    p_tap_reset_r8: assert property (@(posedge clk) disable iff (rst)
        tap_reset |=> (cmd == '0) && sel == SEL_BYPASS);
endmodule

// File: rtl/jdbg_dr_select.sv
module jdbg_dr_select
    import jdbg_pkg::*;
#(
    parameter int IR_W   = 4,
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16,
    parameter logic [IR_W-1:0] IR_HALT   = 4'h7,
    parameter logic [IR_W-1:0] IR_ACCESS = 4'h6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tap_reset_i,
    input  logic              capture_dr_i,
    input  logic              shift_dr_i,
    input  logic              update_dr_i,
    input  logic              update_ir_i,
    input  logic              tdi_i,
    input  logic [IR_W-1:0]   ir_code_i,
    input  logic              halt_granted_i,
    input  logic [CMD_W-1:0]  status_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              tdo_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_we_o,
    output logic              halt_req_o
);
    path_sel_e         sel;
    logic [DATA_W-1:0] sr;
    logic              load_rd;

    assign load_rd = (sel == SEL_DATA) && cmd_is_read(cmd_o[7:0]);

    jdbg_halt_latch #(.IR_W(IR_W), .IR_HALT(IR_HALT)) u_halt (
        .clk(clk), .rst(rst), .update_ir(update_ir_i), .ir_code(ir_code_i),
        .granted(halt_granted_i), .halt_req(halt_req_o)
    );

    jdbg_shifter #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .sel(sel), .capture(capture_dr_i),
        .shift(shift_dr_i), .load_rd(load_rd), .tdi(tdi_i),
        .status(status_i), .rd_data(rd_data_i), .sr(sr), .tdo(tdo_o)
    );

    jdbg_path_fsm #(.IR_W(IR_W), .CMD_W(CMD_W), .DATA_W(DATA_W),
                    .IR_ACCESS(IR_ACCESS)) u_fsm (
        .clk(clk), .rst(rst), .tap_reset(tap_reset_i), .update_ir(update_ir_i),
        .update_dr(update_dr_i), .ir_code(ir_code_i), .sr(sr), .sel(sel),
        .cmd(cmd_o), .data(data_o), .data_we(data_we_o)
    );
endmodule

// File: tb/jdbg_dr_select_tb.sv
`timescale 1ns/1ps
module jdbg_dr_select_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tap_reset = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, updir = 1'b0, tdi = 1'b0;
    logic [3:0]  ir = 4'h0;
    logic        granted = 1'b0;
    logic [7:0]  status = 8'h00;
    logic [15:0] rd_data = 16'h0000;
    logic        tdo, we, halt;
    logic [7:0]  cmd;
    logic [15:0] data;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    jdbg_dr_select u_dut (
        .clk(clk), .rst(rst), .tap_reset_i(tap_reset), .capture_dr_i(cap),
        .shift_dr_i(sh), .update_dr_i(upd), .update_ir_i(updir), .tdi_i(tdi),
        .ir_code_i(ir), .halt_granted_i(granted), .status_i(status),
        .rd_data_i(rd_data), .tdo_o(tdo), .cmd_o(cmd), .data_o(data),
        .data_we_o(we), .halt_req_o(halt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ir_load(input logic [3:0] code);
        @(negedge clk); ir = code; updir = 1'b1;
        @(negedge clk); updir = 1'b0;
    endtask

    // Full DR scan: capture, n shifts, update. Returns bits seen on TDO.
    task automatic dr_scan(input int n, input logic [15:0] din, output logic [15:0] dout);
        dout = '0;
        @(negedge clk); cap = 1'b1;
        @(negedge clk); cap = 1'b0;
        for (int i = 0; i < n; i++) begin
            sh = 1'b1; tdi = din[i];
            #1 dout[i] = tdo;
            @(negedge clk);
        end
        sh = 1'b0; upd = 1'b1;
        @(negedge clk); upd = 1'b0;
    endtask

    initial begin
        logic [15:0] o;
        logic [15:0] wd, rv, exp_b;
        logic [7:0]  c;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        check("R1 halt", halt, 0);
        check("R1 cmd", cmd, 0);
        check("R1 data", data, 0);
        check("R1 we", we, 0);
        check("R1 tdo", tdo, 0);

        // R3 bypass in the idle path
        dr_scan(8, 16'h00B2, o);
        exp_b = {8'h00, 8'hB2 << 1};
        check("R3 bypass tdo", o, exp_b);
        check("R3 cmd kept", cmd, 0);
        check("R3 we quiet", we, 0);

        // R2 halt latch
        ir_load(4'h7);
        check("R2 halt set", halt, 1);
        dr_scan(6, 16'h002D, o);
        check("R3 bypass under halt instr", o, {10'h0, 6'h2D << 1} & 16'h003F);
        ir_load(4'h6);
        check("R2 halt persists", halt, 1);
        @(negedge clk); tap_reset = 1'b1; @(negedge clk); tap_reset = 1'b0;
        check("R2 halt survives tap reset", halt, 1);
        @(negedge clk); granted = 1'b1; @(negedge clk); granted = 1'b0;
        check("R2 halt cleared", halt, 0);
        @(negedge clk); granted = 1'b1; ir = 4'h7; updir = 1'b1;
        @(negedge clk); granted = 1'b0; updir = 1'b0;
        check("R2 grant priority", halt, 0);

        // Sweep every register select
        ir_load(4'h6);
        for (int s = 0; s < 64; s++) begin
            // wide write
            status = 8'(s) ^ 8'hA5;
            c = {1'b0, 1'b1, 6'(s)};
            dr_scan(8, {8'h00, c}, o);
            check("R4 status out", o, {8'h00, status});
            check("R4 cmd load", cmd, c);
            wd = 16'(s * 1027) ^ 16'h5A3C;
            dr_scan(16, wd, o);
            check("R6 data", data, wd);
            check("R6 we high", we, 1);
            @(negedge clk); #1;
            check("R6 we one cycle", we, 0);
            // wide read
            c = {1'b1, 1'b1, 6'(s)};
            dr_scan(8, {8'h00, c}, o);
            check("R5 read cmd", cmd, c);
            rv = ~(16'(s * 257) + 16'(s));
            rd_data = rv;
            dr_scan(16, 16'hFFFF, o);
            check("R7 read out", o, rv);
            check("R7 no we", we, 0);
            check("R7 data kept", data, wd);
            // narrow command keeps 8-bit path
            c = {1'b1, 1'b0, 6'(s)};
            dr_scan(8, {8'h00, c}, o);
            check("R5 narrow cmd", cmd, c);
            c = {1'b0, 1'b0, ~6'(s)};
            dr_scan(8, {8'h00, c}, o);
            check("R5 stays 8-bit status", o, {8'h00, status});
            check("R5 stays 8-bit cmd", cmd, c);
            check("R5 no we", we, 0);
        end

        // R8 TAP reset
        dr_scan(8, 16'h0055, o);
        @(negedge clk); tap_reset = 1'b1; @(negedge clk); tap_reset = 1'b0; #1;
        check("R8 cmd cleared", cmd, 0);
        dr_scan(4, 16'h000D, o);
        check("R8 bypass after reset", o, 16'h000A);
        check("R8 cmd still zero", cmd, 0);

        // R3 leaving the access instruction selects bypass
        ir_load(4'h6);
        dr_scan(8, 16'h0041, o);
        ir_load(4'h2);
        dr_scan(3, 16'h0005, o);
        check("R3 bypass after other instr", o, 16'h0002);
        check("R3 cmd unchanged", cmd, 8'h41);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule